// File: doc/BRIEF.md
# Spread-Spectrum Fractional Divide-Ratio Generator

This block sits beside the multimodulus feedback divider of a fractional-N clock synthesizer and hands it one integer divide ratio per reference cycle. The programmed nominal ratio has an integer part and a binary fraction. When spreading is switched on, a logic-generated triangle lowers that nominal ratio by a fractional amount that climbs linearly from zero to a programmable depth and back, so the synthesized frequency only ever moves downward from nominal (down-spread).

The lowered ratio goes to a third-order sigma-delta requantizer, built as three cascaded first-order accumulators. It emits integers whose running average equals the fractional target and pushes the quantization error toward high frequencies, where the synthesizer loop filters it out. The ramp step and the half-period length (in reference cycles) are inputs. For example, a half-period of about 397 cycles at a 25 MHz reference gives a modulation rate near 31.5 kHz. The depth is set as step times half-period, for example about 0.5 % of the ratio.

Top module: `ssc_ratio_gen`

## Requirements
- R1: While reset is low the ratio output is 0. After reset the ramp offset is zero, the ramp is heading downward, and all accumulators are zero.
- R2: While en is low no state changes and the ratio output keeps its last value.
- R3: With spreading off and nom_frac = 0, every output after an enabled clock edge equals nom_int.
- R4: With spreading off, every output lies between nom_int − 3 and nom_int + 4.
- R5: With spreading off, the sum of any W consecutive outputs is within 4 of W·(nom_int + nom_frac/2^FRAC_W).
- R6: With spreading on, the offset advances by step each enabled cycle for half_cycles cycles starting from zero, then retreats by step for half_cycles cycles back to exactly zero, and repeats. A full period of 2·half_cycles outputs therefore sums to within 4 of 2H·N − step·H²/2^FRAC_W. Here N is the nominal ratio and H is half_cycles.
- R7: Starting from reset, the outputs after edges 1 to H of each period (the falling half) sum to within 4 of H·N − step·H(H−1)/2/2^FRAC_W.
- R8: The outputs after edges H+1 to 2H of each period (the rising half) sum to within 4 of H·N − step·H(H+1)/2/2^FRAC_W.
- R9: An enabled edge with spread_en low clears the offset to zero and re-arms the downward ramp. From the following output onward, the outputs average to the nominal ratio within the tolerance of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advance one step per reference cycle |
| spread_en | input | 1 | Enable triangular down-spread |
| nom_int | input | INT_W | Integer part of nominal ratio |
| nom_frac | input | FRAC_W | Fractional part of nominal ratio |
| step | input | FRAC_W | Offset change per cycle, in units of 2^-FRAC_W |
| half_cycles | input | CNT_W | Reference cycles per ramp half |
| ratio | output | INT_W | Integer divide ratio for the current cycle |

## Verification
Each ratio is registered, so an output appears at the edge after the inputs and ramp state that produced it. The ramp value that edge uses is the one held before the edge, so the first output after reset reflects zero offset. The bench drives and samples on the falling clock edge. It starts each half-period window at the first edge after reset, which lines every summed output up with a known ramp value. Windows that follow a change of spread_en discard the one output still formed from the old offset.

// File: rtl/ssc_ratio_gen.sv
module ssc_ratio_gen #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              spread_en,
  input  logic [INT_W-1:0]  nom_int,
  input  logic [FRAC_W-1:0] nom_frac,
  input  logic [FRAC_W-1:0] step,
  input  logic [CNT_W-1:0]  half_cycles,
  output logic [INT_W-1:0]  ratio
);
  localparam int W = INT_W + FRAC_W;
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [W-1:0]      mag;
  logic [CNT_W-1:0]  cnt;
  logic              going_dn;
  logic [FRAC_W-1:0] a1, a2, a3;
  logic              c2d, c3d, c3dd;

  wire [W-1:0]      step_x = {{INT_W{1'b0}}, step};
  wire [W-1:0]      target = {nom_int, nom_frac} - mag;
  wire [FRAC_W-1:0] xf = target[FRAC_W-1:0];
  wire [INT_W-1:0]  xi = target[W-1:FRAC_W];

  wire [FRAC_W:0] s1 = {1'b0, a1} + {1'b0, xf};
  wire [FRAC_W:0] s2 = {1'b0, a2} + {1'b0, s1[FRAC_W-1:0]};
  wire [FRAC_W:0] s3 = {1'b0, a3} + {1'b0, s2[FRAC_W-1:0]};

  wire signed [3:0] b1   = {3'b000, s1[FRAC_W]};
  wire signed [3:0] b2   = {3'b000, s2[FRAC_W]};
  wire signed [3:0] b2d  = {3'b000, c2d};
  wire signed [3:0] b3   = {3'b000, s3[FRAC_W]};
  wire signed [3:0] b3d  = {2'b00, c3d, 1'b0};
  wire signed [3:0] b3dd = {3'b000, c3dd};
  wire signed [3:0] dy   = b1 + b2 - b2d + b3 - b3d + b3dd;

  wire signed [INT_W+1:0] r_next = $signed({2'b00, xi}) + dy;
  wire turn = (cnt + ONE) >= half_cycles;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a1 <= '0; a2 <= '0; a3 <= '0;
      c2d <= 1'b0; c3d <= 1'b0; c3dd <= 1'b0;
      ratio <= '0;
      mag <= '0; cnt <= '0; going_dn <= 1'b1;
    end else if (en) begin
      a1 <= s1[FRAC_W-1:0];
      a2 <= s2[FRAC_W-1:0];
      a3 <= s3[FRAC_W-1:0];
      c2d <= s2[FRAC_W];
      c3d <= s3[FRAC_W];
      c3dd <= c3d;
      ratio <= r_next[INT_W-1:0];
      if (!spread_en) begin
        mag <= '0; cnt <= '0; going_dn <= 1'b1;
      end else begin
        mag <= going_dn ? mag + step_x : mag - step_x;
        if (turn) begin
          cnt <= '0;
          going_dn <= !going_dn;
        end else begin
          cnt <= cnt + ONE;
        end
      end
    end
  end

  a_r4_offset_range: assert property (@(posedge clk) disable iff (!rst_n)
    (dy >= -4'sd3) && (dy <= 4'sd4));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(ratio) && $stable(mag) && $stable(a1));

  a_r6_ramp_track: assert property (@(posedge clk) disable iff (!rst_n)
    spread_en |-> (going_dn ? mag == W'(cnt) * W'(step)
                            : mag == W'(half_cycles - cnt) * W'(step)));

  a_r9_spread_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !spread_en) |=> (mag == '0) && going_dn);
endmodule

// File: tb/ssc_ratio_gen_test.sv
module ssc_ratio_gen_test;
  localparam int INT_W = 8, FRAC_W = 16, CNT_W = 12;
  localparam longint ONE_F = 64'd1 << FRAC_W;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, spread_en = 1'b0;
  logic [INT_W-1:0]  nom_int = '0;
  logic [FRAC_W-1:0] nom_frac = '0, step = '0;
  logic [CNT_W-1:0]  half_cycles = 12'd1;
  logic [INT_W-1:0]  ratio;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  ssc_ratio_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .spread_en(spread_en),
    .nom_int(nom_int), .nom_frac(nom_frac), .step(step),
    .half_cycles(half_cycles), .ratio(ratio));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; en = 1'b0; spread_en = 1'b0;
    tick; tick;
    chk(ratio == 0, "R1 reset ratio", ratio, 0);
    rst_n = 1'b1;
  endtask

  function automatic longint absl(input longint v);
    return v < 0 ? -v : v;
  endfunction

  task automatic win_sum(input int n, output longint s);
    s = 0;
    for (int k = 0; k < n; k++) begin
      tick;
      s += longint'(ratio);
    end
  endtask

  initial begin
    longint s, s2, nomv, exp, hval, sv;
    bit ok;
    int prev;
    tick;
    do_reset;

    // R3: exact integer ratio when the fraction is zero
    nom_int = 8'd37; nom_frac = '0; en = 1'b1;
    for (int k = 0; k < 16; k++) begin
      tick;
      chk(ratio == 37, "R3 integer ratio", ratio, 37);
    end

    // R4, R5: fractional ratio without spreading
    do_reset;
    nom_int = 8'd50; nom_frac = 16'h5A3C; en = 1'b1;
    nomv = 50 * ONE_F + 64'h5A3C;
    for (int w = 0; w < 3; w++) begin
      s = 0; ok = 1'b1;
      for (int k = 0; k < 64; k++) begin
        tick;
        s += longint'(ratio);
        if (ratio < 47 || ratio > 54) ok = 1'b0;
      end
      chk(ok, "R4 range nom-3..nom+4", ratio, 50);
      chk(absl(s * ONE_F - 64 * nomv) <= 4 * ONE_F, "R5 window sum", s, (64 * nomv) / ONE_F);
    end

    // R2: hold while disabled
    en = 1'b0;
    tick;
    prev = ratio;
    for (int k = 0; k < 8; k++) begin
      tick;
      chk(ratio == prev, "R2 hold", ratio, prev);
    end
    en = 1'b1;

    // R1, R6, R7, R8: triangle after reset starts at zero offset heading down
    do_reset;
    nom_int = 8'd40; nom_frac = 16'h1234; step = 16'd1000; half_cycles = 12'd64;
    spread_en = 1'b1; en = 1'b1;
    nomv = 40 * ONE_F + 64'h1234;
    hval = 64; sv = 1000;
    for (int p = 0; p < 3; p++) begin
      win_sum(64, s);
      exp = hval * nomv - sv * hval * (hval - 1) / 2;
      chk(absl(s * ONE_F - exp) <= 4 * ONE_F, "R7 falling half", s, exp / ONE_F);
      win_sum(64, s2);
      exp = hval * nomv - sv * hval * (hval + 1) / 2;
      chk(absl(s2 * ONE_F - exp) <= 4 * ONE_F, "R8 rising half", s2, exp / ONE_F);
      exp = 2 * hval * nomv - sv * hval * hval;
      chk(absl((s + s2) * ONE_F - exp) <= 4 * ONE_F, "R6 full period", s + s2, exp / ONE_F);
    end

    // R9: dropping spread mid-ramp returns to nominal
    win_sum(30, s);
    spread_en = 1'b0;
    tick;
    win_sum(64, s);
    chk(absl(s * ONE_F - 64 * nomv) <= 4 * ONE_F, "R9 spread cleared", s, (64 * nomv) / ONE_F);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule